// File: doc/BRIEF.md
# Power-Down Entry and Wake Sequencer

This block sequences a microcontroller's entry into and exit from its low-power state. Software raises a power-down request bit. The block then waits a fixed grace period of 32 clock edges, so that the program can halt the processor core. After that it drives a shutdown signal to the analog circuits. While the block is powered down the clock is stopped. Any enabled wake source (eight user interrupt lines, a card interrupt and a keypad interrupt, merged by OR) drops the shutdown signal directly, without a clock edge, so that the oscillator and clocks can restart.

Once the clock runs again, a 9-bit settling counter counts 512 edges. Only then does the block raise the processor interrupt. The interrupt stays high until software clears the request bit, and the block then returns to idle with both counters cleared. A routing select bit decides whether the merged wake sources take part at all. Software sets it before it raises the request bit. A wake that arrives inside the grace period cancels the shutdown before the shutdown signal ever rises.

Top module: `pd_wake_seq`

## Requirements
- R1: While rst_ni is low, ana_off_o and cpu_irq_o are 0, whether or not the clock runs.
- R2: With the request held high from idle, ana_off_o is still 0 after the 31st rising edge and is 1 after the 32nd rising edge, counting the first edge that sees the request.
- R3: Dropping the request before the 32nd edge returns the block to idle without asserting ana_off_o. A later request again takes the full 32 edges.
- R4: Wake sources are usr_irq_i[0..7], card_irq_i and key_irq_i. With wake_route_i = 1, any single one of them, held high while the block is powered down, drives ana_off_o to 0 at once, with no clock edge.
- R5: With wake_route_i = 0, the wake sources have no effect in the powered-down state: ana_off_o stays 1 and cpu_irq_o stays 0 until reset.
- R6: cpu_irq_o is 0 after the 511th rising edge and 1 after the 512th rising edge. The count starts with the first edge at which the powered-down block sees a wake.
- R7: A routed wake seen on an edge during the grace period moves the block straight to settling. ana_off_o never rises, and cpu_irq_o rises after the 512th edge, counting that edge as the first.
- R8: If a routed wake is present on the same edge that would end the grace period (the 32nd), the wake wins: ana_off_o stays 0 and settling starts on that edge.
- R9: cpu_irq_o stays 1 while the request stays high. After the first edge with the request low, both outputs are 0. ana_off_o and cpu_irq_o are never 1 together.
- R10: In idle with the request low, the wake sources have no effect: both outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock; stopped externally while shut down |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Power-down request bit from software |
| wake_route_i | input | 1 | 1: merged wake sources may wake the block and raise the interrupt |
| usr_irq_i | input | N_USR (8) | User wake interrupt lines |
| card_irq_i | input | 1 | Card interface wake interrupt |
| key_irq_i | input | 1 | Keypad wake interrupt |
| ana_off_o | output | 1 | Shutdown command to the analog circuits |
| cpu_irq_o | output | 1 | Delayed wake interrupt to the processor |

## Verification
Two events can fall on the same clock edge: the grace counter reaching terminal count, and a routed wake arriving. The bench sweeps the wake arrival across every edge of the grace period, including the 32nd. In that last case the terminal count and the wake fall on one edge, and the bench requires that the shutdown signal never rises and that the interrupt follows exactly 512 edges later. The bench gates the clock itself from ana_off_o, so the combinational release and the count from clock restart are both judged at the ports.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_DOWN,
    ST_SETTLE,
    ST_IRQ
  } pd_state_e;
endpackage

// File: rtl/pd_wake_cnt.sv
module pd_wake_cnt #(
  parameter int unsigned W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic clr_i,
  output logic tc_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ce_i)   cnt_q <= cnt_q + W'(1);
  end

  // terminal count: enabled increment from all ones
  assign tc_o = ce_i & ~clr_i & (&cnt_q);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !clr_i) |=> (cnt_q == ($past(cnt_q) + W'(1)))); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R3
endmodule

// File: rtl/pd_wake_merge.sv
module pd_wake_merge #(
  parameter int unsigned N_USR = 8
) (
  input  logic [N_USR-1:0] usr_irq_i,
  input  logic             card_irq_i,
  input  logic             key_irq_i,
  input  logic             route_i,
  output logic             wake_o
);
  logic any_src;

  assign any_src = (|usr_irq_i) | card_irq_i | key_irq_i;
  assign wake_o  = route_i & any_src;
endmodule

// File: rtl/pd_wake_seq.sv
module pd_wake_seq
  import pd_wake_pkg::*;
#(
  parameter int unsigned N_USR    = 8,
  parameter int unsigned GRACE_W  = 5,
  parameter int unsigned SETTLE_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_i,
  input  logic             wake_route_i,
  input  logic [N_USR-1:0] usr_irq_i,
  input  logic             card_irq_i,
  input  logic             key_irq_i,
  output logic             ana_off_o,
  output logic             cpu_irq_o
);
  pd_state_e state_q, state_d;
  logic      wake;
  logic      g_ce, g_tc;
  logic      s_ce, s_tc;

  pd_wake_merge #(.N_USR(N_USR)) u_merge (
    .usr_irq_i  (usr_irq_i),
    .card_irq_i (card_irq_i),
    .key_irq_i  (key_irq_i),
    .route_i    (wake_route_i),
    .wake_o     (wake)
  );

  // grace counter runs on every edge that keeps the request alive with no wake
  assign g_ce = pd_req_i & ~wake & ((state_q == ST_IDLE) | (state_q == ST_GRACE))
              | pd_req_i & (state_q == ST_IDLE);
  // settle counter counts the wake edge itself as the first
  assign s_ce = (state_q == ST_SETTLE)
              | (wake & (state_q == ST_DOWN))
              | (wake & pd_req_i & (state_q == ST_GRACE));

  pd_wake_cnt #(.W(GRACE_W)) u_grace_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (g_ce),
    .clr_i  (~g_ce),
    .tc_o   (g_tc)
  );

  pd_wake_cnt #(.W(SETTLE_W)) u_settle_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (s_ce),
    .clr_i  (~s_ce),
    .tc_o   (s_tc)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (pd_req_i) state_d = ST_GRACE;
      ST_GRACE: begin
        if (!pd_req_i)  state_d = ST_IDLE;
        else if (wake)  state_d = ST_SETTLE;  // wake beats terminal count
        else if (g_tc)  state_d = ST_DOWN;
      end
      ST_DOWN:   if (wake) state_d = ST_SETTLE;
      ST_SETTLE: if (s_tc) state_d = ST_IRQ;
      ST_IRQ:    if (!pd_req_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // release is combinational: the clock is stopped while down
  assign ana_off_o = (state_q == ST_DOWN) & ~wake;
  assign cpu_irq_o = (state_q == ST_IRQ);

  AST_DOWN_FROM_GRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN && $past(state_q) != ST_DOWN) |-> $past(state_q == ST_GRACE)); // R2
  AST_IRQ_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_irq_o) |-> $past(state_q == ST_SETTLE)); // R6
  AST_OFF_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ana_off_o && cpu_irq_o)); // R9
  AST_UNROUTED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOWN && !wake_route_i) |=> (state_q == ST_DOWN)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !pd_req_i) |=> (state_q == ST_IDLE)); // R10
  AST_GRACE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GRACE && pd_req_i && wake) |=> (state_q == ST_SETTLE)); // R7
endmodule

// File: tb/pd_wake_seq_bench.sv
module pd_wake_seq_bench;
  logic       clk = 1'b0;
  logic       en = 1'b1;
  logic       gclk;
  logic       rst_n = 1'b0;
  logic       pd_req = 1'b0;
  logic       route = 1'b1;
  logic [7:0] usr = '0;
  logic       card = 1'b0;
  logic       key = 1'b0;
  logic       ana_off, cpu_irq;
  int         n_chk = 0;
  int         n_fail = 0;

  always #10 clk = ~clk;
  // clock gate modelled from the shutdown output, updated while clk is low
  always @(negedge clk) en <= ~ana_off;
  assign gclk = clk & en;

  pd_wake_seq u_pd_wake_seq (
    .clk_i        (gclk),
    .rst_ni       (rst_n),
    .pd_req_i     (pd_req),
    .wake_route_i (route),
    .usr_irq_i    (usr),
    .card_irq_i   (card),
    .key_irq_i    (key),
    .ana_off_o    (ana_off),
    .cpu_irq_o    (cpu_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic set_src(input int idx, input logic v);
    if (idx < 8) usr[idx] = v;
    else if (idx == 8) card = v;
    else key = v;
  endtask

  // request from idle, check 31/32 edge boundary
  task automatic enter_down(input string req);
    step(); pd_req = 1'b1;
    tick(31); check(req, ana_off, 0);
    tick(1);  check(req, ana_off, 1);
  endtask

  // wake from down through source idx, check 512-edge settle, then release
  task automatic wake_settle(input int idx);
    step(); set_src(idx, 1'b1);
    #1 check("R4", ana_off, 0);
    tick(1);                 // clock gate reopens, no edge yet
    tick(3);
    step(); set_src(idx, 1'b0);
    tick(507); check("R6", cpu_irq, 0);
    tick(1);   check("R6", cpu_irq, 1);
    tick(4);   check("R9", cpu_irq, 1);
    step(); pd_req = 1'b0;
    tick(1);   check("R9", cpu_irq, 0);
    check("R9", ana_off, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(2);
    check("R1", ana_off, 0);
    check("R1", cpu_irq, 0);
    step(); rst_n = 1'b1;
    tick(2);

    // R2/R4/R6: every wake source
    for (int s = 0; s < 10; s++) begin
      enter_down("R2");
      wake_settle(s);
    end

    // R3: abort after k grace edges, then full 32 on restart
    for (int k = 1; k <= 30; k++) begin
      step(); pd_req = 1'b1;
      tick(k);
      step(); pd_req = 1'b0;
      tick(2); check("R3", ana_off, 0);
      enter_down("R3");
      wake_settle(9);
    end

    // R7/R8: wake after j+1 grace edges; j=30 collides with terminal count
    for (int j = 0; j <= 30; j++) begin
      step(); pd_req = 1'b1;
      tick(j);
      step(); key = 1'b1;
      tick(3);
      step(); key = 1'b0;
      tick(507);
      check((j == 30) ? "R8" : "R7", ana_off, 0);
      check((j == 30) ? "R8" : "R7", cpu_irq, 0);
      tick(1);
      check((j == 30) ? "R8" : "R7", cpu_irq, 1);
      step(); pd_req = 1'b0;
      tick(2);
      check("R9", cpu_irq, 0);
    end

    // R10: wake sources in idle
    step(); usr = 8'hFF; card = 1'b1; key = 1'b1;
    tick(40);
    check("R10", ana_off, 0);
    check("R10", cpu_irq, 0);
    step(); usr = '0; card = 1'b0; key = 1'b0;

    // R5: unrouted wake ignored while down
    step(); route = 1'b0;
    enter_down("R2");
    step(); usr = 8'hFF; card = 1'b1; key = 1'b1;
    #1 check("R5", ana_off, 1);
    tick(6);
    check("R5", ana_off, 1);
    check("R5", cpu_irq, 0);
    step(); rst_n = 1'b0;
    #1 check("R1", ana_off, 0);
    check("R1", cpu_irq, 0);
    usr = '0; card = 1'b0; key = 1'b0; pd_req = 1'b0;
    step(); rst_n = 1'b1; route = 1'b1;
    tick(3);
    check("R1", ana_off, 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule